// File: doc/BRIEF.md
# Triggered Stream Capture Window

This block sits between a slow sample stream (an ADC producing a new sample every few dozen stream-clock cycles) and a DMA engine that starts a transfer on a sync flag. The trigger input is asynchronous. The block synchronizes it and detects its rising edge. On that edge it opens a capture window. The window forwards a programmed number of accepted samples as one packet. The first forwarded beat carries `m_tuser[0]` and the final beat carries `m_tlast`.

The window length counts accepted valid beats, not clock cycles. A sparse valid stream therefore yields exactly the programmed number of distinct samples. Outside the window the block accepts every sample and discards it, so the upstream source never stalls. A mode input bypasses the window altogether and passes every sample through without framing.

Top module: `trig_capture_window`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `m_tvalid` is 0. After reset the block is idle with a zero beat count, so nothing is forwarded in capture mode until a trigger edge arrives.
- R2: `trig_async` passes through a SYNC_STAGES-flop synchronizer followed by an edge register. A 0-to-1 transition seen at the synchronizer output opens the window. A trigger held high opens it only once.
- R3: In capture mode (`mode_capture`=1), `m_tuser` is 1 on the first forwarded beat of a window and on no other beat.
- R4: The beat count advances only on a full handshake (`m_tvalid` and `m_tready` both 1). A window forwards exactly the programmed number of beats, whatever the spacing of the input valids.
- R5: `m_tlast` is 1 on the final (Nth) forwarded beat. The window closes once that beat is accepted.
- R6: In capture mode with no window open, `s_tready` is 1 and `m_tvalid` is 0, so input samples are taken and dropped.
- R7: While a window is open, `m_tvalid` equals `s_tvalid`, `s_tready` equals `m_tready`, and `m_tdata` equals `s_tdata`.
- R8: With `mode_capture`=0, every sample passes through (`m_tvalid`=`s_tvalid`, `s_tready`=`m_tready`), and `m_tuser` and `m_tlast` stay 0.
- R9: Trigger edges that arrive while a window is open are ignored. The window re-arms only after its final beat has been accepted.
- R10: A programmed length of 0 is taken as 1. The single beat then carries both `m_tuser` and `m_tlast`.
- R11: The length is sampled when the window opens. Changes to `cap_len` during a window do not affect that window.
- R12: Dropping `mode_capture` to 0 abandons an open window. A later return to capture mode waits for a new trigger edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_async | input | 1 | Asynchronous external trigger |
| mode_capture | input | 1 | 1 = triggered capture, 0 = continuous pass-through |
| cap_len | input | CNT_W | Beats per window (0 counts as 1) |
| s_tdata | input | DATA_W | Input sample data |
| s_tvalid | input | 1 | Input sample valid |
| s_tready | output | 1 | Input ready |
| m_tdata | output | DATA_W | Forwarded sample data |
| m_tvalid | output | 1 | Forwarded sample valid |
| m_tready | input | 1 | Downstream ready |
| m_tuser | output | 1 | Start-of-capture flag (first beat) |
| m_tlast | output | 1 | End-of-capture flag (last beat) |

## Verification
The assertions assume the upstream source obeys the stream rule: once valid is raised, it holds the sample until it is accepted. They also assume the trigger stays at each level long enough for the synchronizer to see it. The stimulus only withdraws or replaces a sample after a handshake it has observed, and it holds the trigger high or low for several cycles at a time. Input valids are sparse (roughly one in four cycles) and downstream ready is varied at random. A behavioural model that tracks the window, the beat count and the latched length predicts every output each cycle.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
   typedef enum logic {
      MODE_STREAM  = 1'b0,
      MODE_CAPTURE = 1'b1
   } tcw_mode_e;

   localparam int TCW_MIN_SYNC = 2;
endpackage

// File: rtl/tcw_trig_sync.sv
module tcw_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_async,
   output logic rise
);
   import tcw_pkg::*;

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES < TCW_MIN_SYNC) begin : g_bad_stages
      $error("tcw_trig_sync: STAGES must be at least %0d", TCW_MIN_SYNC);
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= trig_async;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign rise = chain_q[STAGES-1] & ~prev_q;

   // a detected edge is a one-cycle pulse (R2)
   assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/tcw_window_ctrl.sv
module tcw_window_ctrl #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture_en,
   input  logic             rise,
   input  logic             beat_acc,
   input  logic [CNT_W-1:0] cap_len,
   output logic             active,
   output logic             first,
   output logic             last
);
   logic             active_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_idx_q;
   logic [CNT_W-1:0] last_idx_d;

   assign last_idx_d = (cap_len == '0) ? '0 : cap_len - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         cnt_q      <= '0;
         last_idx_q <= '0;
      end else if (!capture_en) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (active_q) begin
         if (beat_acc) begin
            if (cnt_q == last_idx_q) begin
               active_q <= 1'b0;
               cnt_q    <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end else if (rise) begin
         active_q   <= 1'b1;
         cnt_q      <= '0;
         last_idx_q <= last_idx_d;
      end
   end

   assign active = active_q;
   assign first  = active_q && (cnt_q == '0);
   assign last   = active_q && (cnt_q == last_idx_q);

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!active_q && cnt_q == '0));

   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (cnt_q <= last_idx_q));

   assert_hold_no_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && capture_en && !beat_acc) |=> (active_q && $stable(cnt_q) && $stable(last_idx_q)));

   assert_len_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && capture_en) |=> $stable(last_idx_q));
endmodule

// File: rtl/tcw_stream_gate.sv
module tcw_stream_gate #(
   parameter int DATA_W = 64
) (
   input  logic              run,
   input  logic              capture_en,
   input  logic              active,
   input  logic              first,
   input  logic              last,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic              s_tvalid,
   output logic              s_tready,
   output logic [DATA_W-1:0] m_tdata,
   output logic              m_tvalid,
   input  logic              m_tready,
   output logic              m_tuser,
   output logic              m_tlast
);
   logic fwd;

   always_comb begin
      fwd      = capture_en ? active : 1'b1;
      m_tvalid = run & s_tvalid & fwd;
      s_tready = fwd ? m_tready : 1'b1;
      m_tdata  = s_tdata;
      m_tuser  = capture_en & first;
      m_tlast  = capture_en & last;
   end
endmodule

// File: rtl/trig_capture_window.sv
module trig_capture_window #(
   parameter int DATA_W      = 64,
   parameter int CNT_W       = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_async,
   input  logic              mode_capture,
   input  logic [CNT_W-1:0]  cap_len,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic              s_tvalid,
   output logic              s_tready,
   output logic [DATA_W-1:0] m_tdata,
   output logic              m_tvalid,
   input  logic              m_tready,
   output logic              m_tuser,
   output logic              m_tlast
);
   import tcw_pkg::*;

   localparam int MAX_LEN_LOG = CNT_W;

   if (DATA_W < 1) begin : g_bad_data
      $error("trig_capture_window: DATA_W must be positive");
   end
   if (MAX_LEN_LOG < 1 || MAX_LEN_LOG > 32) begin : g_bad_cnt
      $error("trig_capture_window: CNT_W must be within 1..32");
   end

   tcw_mode_e mode;
   logic      capture_en;
   logic      rise;
   logic      active;
   logic      first;
   logic      last;
   logic      beat_acc;

   assign mode       = tcw_mode_e'(mode_capture);
   assign capture_en = (mode == MODE_CAPTURE);
   assign beat_acc   = m_tvalid & m_tready;

   tcw_trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_async (trig_async),
      .rise       (rise)
   );

   tcw_window_ctrl #(.CNT_W(CNT_W)) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_en (capture_en),
      .rise       (rise),
      .beat_acc   (beat_acc),
      .cap_len    (cap_len),
      .active     (active),
      .first      (first),
      .last       (last)
   );

   tcw_stream_gate #(.DATA_W(DATA_W)) gate_i (
      .run        (rst_n),
      .capture_en (capture_en),
      .active     (active),
      .first      (first),
      .last       (last),
      .s_tdata    (s_tdata),
      .s_tvalid   (s_tvalid),
      .s_tready   (s_tready),
      .m_tdata    (m_tdata),
      .m_tvalid   (m_tvalid),
      .m_tready   (m_tready),
      .m_tuser    (m_tuser),
      .m_tlast    (m_tlast)
   );

   assert_valid_from_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> s_tvalid);

   assert_no_stall_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_capture && !active) |-> (s_tready && !m_tvalid));

   assert_user_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && m_tready && m_tuser) |=> !m_tuser);

   assert_close_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && m_tready && m_tlast && mode_capture) |=> !active);

   assert_stream_unframed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_capture |-> (!m_tuser && !m_tlast));

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> !m_tvalid);
endmodule

// File: tb/trig_capture_window_tb_top.sv
`timescale 1ns/100ps
module trig_capture_window_tb_top;
   localparam int DW = 64;
   localparam int CW = 20;
   localparam int S  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig_async = 1'b0;
   logic          mode_capture = 1'b1;
   logic [CW-1:0] cap_len = '0;
   logic [DW-1:0] s_tdata = '0;
   logic          s_tvalid = 1'b0;
   logic          s_tready;
   logic [DW-1:0] m_tdata;
   logic          m_tvalid;
   logic          m_tready = 1'b1;
   logic          m_tuser;
   logic          m_tlast;

   always #2.5 clk = ~clk;

   trig_capture_window #(.DATA_W(DW), .CNT_W(CW), .SYNC_STAGES(S)) dut_i (
      .clk(clk), .rst_n(rst_n), .trig_async(trig_async), .mode_capture(mode_capture),
      .cap_len(cap_len), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
      .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
      .m_tuser(m_tuser), .m_tlast(m_tlast)
   );

   int    total = 0;
   int    bad = 0;
   string cur_tag = "R1";
   bit    done = 0;

   // stimulus knobs
   int    valid_den = 4;
   bit    ready_rand = 0;

   // reference model state
   bit    pipe[$];
   bit    m_open = 0;
   int    m_beats = 0;
   int    m_len = 1;
   bit    acc = 0;
   int    fwd_cnt = 0;
   longint unsigned seq = 0;

   task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      for (int i = 0; i <= S; i++) pipe.push_back(1'b0);
   end

   // model update, drive, check
   initial begin
      forever begin
         @(posedge clk);
         begin
            bit rise;
            bit hs;
            rise = pipe[S-1] && !pipe[S];
            hs   = s_tvalid && m_tready;
            if (!rst_n) begin
               m_open = 0; m_beats = 0; m_len = 1;
               for (int i = 0; i <= S; i++) pipe[i] = 1'b0;
            end else begin
               if (!mode_capture) begin
                  m_open = 0; m_beats = 0;
               end else if (m_open) begin
                  if (hs) begin
                     if (m_beats == m_len - 1) begin m_open = 0; m_beats = 0; end
                     else m_beats++;
                  end
               end else if (rise) begin
                  m_open = 1; m_beats = 0;
                  m_len = (cap_len == 0) ? 1 : int'(cap_len);
               end
               pipe.push_front(trig_async);
               void'(pipe.pop_back());
            end
         end
         #1;
         if (acc) seq++;
         if (!s_tvalid || acc) s_tvalid = ($urandom_range(0, valid_den - 1) == 0);
         s_tdata  = {32'h5A00_0000, seq[31:0]};
         m_tready = ready_rand ? 1'($urandom_range(0, 1)) : 1'b1;
         @(negedge clk);
         begin
            bit e_tv, e_tr, e_us, e_la;
            e_tv = rst_n && s_tvalid && (!mode_capture || m_open);
            e_tr = mode_capture ? (m_open ? m_tready : 1'b1) : m_tready;
            e_us = mode_capture && m_open && (m_beats == 0);
            e_la = mode_capture && m_open && (m_beats == m_len - 1);
            chk(m_tvalid === e_tv, cur_tag, "m_tvalid", 64'(m_tvalid), 64'(e_tv));
            chk(s_tready === e_tr, cur_tag, "s_tready", 64'(s_tready), 64'(e_tr));
            if (e_tv) begin
               chk(m_tdata === s_tdata, "R7", "m_tdata", m_tdata, s_tdata);
               chk(m_tuser === e_us, "R3", "m_tuser", 64'(m_tuser), 64'(e_us));
               chk(m_tlast === e_la, "R5", "m_tlast", 64'(m_tlast), 64'(e_la));
            end
            if (m_tvalid && m_tready && mode_capture) begin
               if (m_tuser) fwd_cnt = 1; else fwd_cnt++;
               if (m_tlast) chk(fwd_cnt == m_len, "R4", "beats per window", 64'(fwd_cnt), 64'(m_len));
            end
            acc = s_tvalid && s_tready;
         end
      end
   end

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic trig_pulse(int hi);
      trig_async = 1'b1; cyc(hi);
      trig_async = 1'b0;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired act=running exp=finished");
         summary();
      end
   end

   initial begin
      cur_tag = "R1";
      cyc(5);
      chk(m_tvalid === 1'b0, "R1", "m_tvalid in reset", 64'(m_tvalid), 64'd0);
      rst_n = 1'b1;
      cyc(10);
      chk(m_tvalid === 1'b0, "R1", "m_tvalid idle after reset", 64'(m_tvalid), 64'd0);

      cur_tag = "R6"; valid_den = 2;
      cyc(40);

      cur_tag = "R4"; valid_den = 4; cap_len = 5;
      trig_pulse(6); cyc(80);

      cur_tag = "R2"; cap_len = 3;
      trig_async = 1'b1; cyc(120);
      trig_async = 1'b0; cyc(10);

      cur_tag = "R7"; ready_rand = 1; cap_len = 7;
      trig_pulse(4); cyc(150);

      cur_tag = "R9"; cap_len = 20;
      trig_pulse(4); cyc(15);
      trig_pulse(4); cyc(10);
      trig_pulse(4); cyc(250);

      cur_tag = "R10"; ready_rand = 0; cap_len = 0;
      trig_pulse(4); cyc(40);

      cur_tag = "R11"; cap_len = 4;
      trig_pulse(4); cap_len = 12; cyc(80);

      cur_tag = "R12"; cap_len = 30;
      trig_pulse(4); cyc(20);
      mode_capture = 1'b0; cyc(5);
      mode_capture = 1'b1; cyc(60);

      cur_tag = "R8"; mode_capture = 1'b0; ready_rand = 1;
      trig_pulse(4); cyc(120);

      cur_tag = "R1"; rst_n = 1'b0; cyc(4);
      chk(m_tvalid === 1'b0, "R1", "m_tvalid in late reset", 64'(m_tvalid), 64'd0);
      rst_n = 1'b1; mode_capture = 1'b1; cyc(20);

      done = 1;
      summary();
   end
endmodule